// File: doc/BRIEF.md
# Keyboard Reply Queue

This block is the device end of a keyboard link that sits behind the receive port of one serial channel. Key events come in as an 8-bit code: the low seven bits select an entry of a translation table and the top bit marks a key release. The translated byte, with the release bit put back on top, is stored in a byte queue. The serial channel reads bytes out of the queue with a read strobe.

Command bytes that the host sends on the transmit side also come into the block. Two commands make the block queue a fixed two-byte reply. All other commands have no effect.

The queue is a power-of-two ring with wrapping read and write pointers and an occupancy count. Its outputs to the serial channel are a level that shows unread bytes are waiting, a one-cycle event pulse that re-arms the receiver, and the byte at the head of the queue.

Top module: `kbd_reply_queue`

## Requirements
- R1: After reset the queue is empty: `rx_avail` is 0, `rx_pulse` is 0 and `rd_data` is 0x00.
- R2: Bytes leave the queue in the order they were accepted. `rd_data` shows the oldest unread byte, and a cycle with `rd_strobe` high removes it.
- R3: The queue holds DEPTH bytes (256 by default). A push made while it holds DEPTH bytes is discarded: it raises no pulse and does not change the stored bytes.
- R4: While the queue is empty, `rd_data` reads 0x00, and a read strobe changes nothing.
- R5: `rx_pulse` is high for one cycle after every accepted push. It is also high for one cycle after a pop that leaves at least one byte in the queue. It is not raised after a pop that empties the queue.
- R6: A key event stores {code[7], T(code[6:0])}. With the default table, T(x) = x XOR 0x55 over 7 bits.
- R7: Command 0x01 queues 0xFF and then 0x05. Command 0x07 queues 0xFE and then 0x20. The two bytes are pushed in the first and second cycles after the command cycle.
- R8: A command byte other than 0x01 or 0x07 queues nothing.
- R9: While a reply is being pushed, the reply takes precedence: a key event in the same cycle is discarded. A command that arrives while a reply is pending is ignored.
- R10: A push and a pop in the same cycle advance both pointers and leave the occupancy count unchanged.
- R11: `rx_avail` is high exactly while the queue holds at least one byte. It goes high in the cycle after the first push and low in the cycle after the last pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | Key event strobe |
| key_code | input | 8 | Bit 7 marks a release, bits 6:0 are the raw key index |
| cmd_valid | input | 1 | Host command strobe |
| cmd_byte | input | 8 | Host command byte |
| rd_strobe | input | 1 | Pops the head byte |
| rd_data | output | 8 | Head byte, or 0x00 when the queue is empty |
| rx_avail | output | 1 | Queue holds at least one byte |
| rx_pulse | output | 1 | Receive event: one cycle after a push, or after a pop that leaves bytes behind |

## Verification
The bench fills the ring to exactly 256 entries and then pushes one more byte. A design that wraps the pointers too early, or accepts the extra byte, would overwrite the oldest entry or return the extra byte at the end. Reads from an empty queue must give 0x00 and leave the count where it is. A design that reads stale memory instead would return old data, and one that underflows the count would raise `rx_avail`.

The bench issues a key event and a second command while a reply is still being pushed. A wrong arbiter would insert the key between 0xFF and 0x05, or start a second reply. It also pushes and pops in the same cycle. A design that lets one of those operations win over the other would lose a byte, or would drop `rx_avail` while bytes are still queued.

// File: rtl/kbq_pkg.sv
package kbq_pkg;

   typedef enum logic [1:0] {
      RS_IDLE   = 2'd0,
      RS_FIRST  = 2'd1,
      RS_SECOND = 2'd2
   } reply_st_t;

   localparam logic [7:0] CMD_RESET  = 8'h01;
   localparam logic [7:0] CMD_LAYOUT = 8'h07;

   typedef struct packed {
      logic       known;
      logic [7:0] first;
      logic [7:0] second;
   } reply_t;

   function automatic reply_t reply_lookup(input logic [7:0] cmd);
      reply_t r;
      r.known  = 1'b0;
      r.first  = 8'h00;
      r.second = 8'h00;
      case (cmd)
         CMD_RESET: begin
            r.known  = 1'b1;
            r.first  = 8'hFF;
            r.second = 8'h05;
         end
         CMD_LAYOUT: begin
            r.known  = 1'b1;
            r.first  = 8'hFE;
            r.second = 8'h20;
         end
         default: r.known = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/kbq_store.sv
module kbq_store #(
   parameter int DEPTH = 256,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [DW-1:0] head_data,
   output logic [CW-1:0] count,
   output logic          push_ok,
   output logic          pop_ok
);

   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;

   assign push_ok   = push && (count != FULL_CNT);
   assign pop_ok    = pop && (count != '0);
   assign head_data = (count != '0) ? mem[rptr] : '0;

   always_ff @(posedge clk) begin
      if (push_ok) mem[wptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push_ok) wptr <= wptr + 1'b1;
         if (pop_ok)  rptr <= rptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_CNT);

   // R3
   full_push_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count == FULL_CNT && push && !pop) |=> (count == FULL_CNT));

   // R4
   empty_pop_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && pop && !push) |=> (count == '0));

   // R10
   push_pop_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_ok && pop_ok) |=> $stable(count));

endmodule

// File: rtl/kbq_xlate.sv
module kbq_xlate #(
   parameter int         XLATE_MODE = 1,
   parameter logic [6:0] XLATE_KEY  = 7'h55
) (
   input  logic [7:0] key_code,
   output logic [7:0] key_byte
);

   logic [6:0] mapped;

   generate
      if (XLATE_MODE == 0) begin : g_pass
         assign mapped = key_code[6:0];
      end else if (XLATE_MODE == 1) begin : g_xor
         assign mapped = key_code[6:0] ^ XLATE_KEY;
      end else if (XLATE_MODE == 2) begin : g_add
         assign mapped = key_code[6:0] + XLATE_KEY;
      end else begin : g_bad_mode
         $error("kbq_xlate: XLATE_MODE must be 0, 1 or 2");
         assign mapped = '0;
      end
   endgenerate

   assign key_byte = {key_code[7], mapped};

endmodule

// File: rtl/kbq_reply.sv
module kbq_reply
   import kbq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [7:0] cmd_byte,
   output logic       out_valid,
   output logic [7:0] out_byte
);

   reply_st_t  state;
   logic [7:0] byte_a, byte_b;
   reply_t     lk;

   assign lk        = reply_lookup(cmd_byte);
   assign out_valid = (state != RS_IDLE);
   assign out_byte  = (state == RS_FIRST) ? byte_a : byte_b;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= RS_IDLE;
         byte_a <= '0;
         byte_b <= '0;
      end else begin
         case (state)
            RS_IDLE: begin
               if (cmd_valid && lk.known) begin
                  state  <= RS_FIRST;
                  byte_a <= lk.first;
                  byte_b <= lk.second;
               end
            end
            RS_FIRST:  state <= RS_SECOND;
            RS_SECOND: state <= RS_IDLE;
            default:   state <= RS_IDLE;
         endcase
      end
   end

   // R7
   reply_sequence_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RS_FIRST) |=> (state == RS_SECOND));

   // R8
   unknown_cmd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RS_IDLE && cmd_valid && !lk.known) |=> (state == RS_IDLE));

endmodule

// File: rtl/kbd_reply_queue.sv
module kbd_reply_queue #(
   parameter int         DEPTH      = 256,
   parameter int         XLATE_MODE = 1,
   parameter logic [6:0] XLATE_KEY  = 7'h55,
   localparam int        AW         = $clog2(DEPTH),
   localparam int        CW         = AW + 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       key_valid,
   input  logic [7:0] key_code,
   input  logic       cmd_valid,
   input  logic [7:0] cmd_byte,
   input  logic       rd_strobe,
   output logic [7:0] rd_data,
   output logic       rx_avail,
   output logic       rx_pulse
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("kbd_reply_queue: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic          seq_valid;
   logic [7:0]    seq_byte;
   logic [7:0]    key_byte;
   logic          push;
   logic [7:0]    push_data;
   logic [CW-1:0] count;
   logic          push_ok, pop_ok;
   logic          pulse_q;

   kbq_xlate #(
      .XLATE_MODE (XLATE_MODE),
      .XLATE_KEY  (XLATE_KEY)
   ) u_xlate (
      .key_code (key_code),
      .key_byte (key_byte)
   );

   kbq_reply u_reply (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_byte  (cmd_byte),
      .out_valid (seq_valid),
      .out_byte  (seq_byte)
   );

   assign push      = seq_valid || key_valid;
   assign push_data = seq_valid ? seq_byte : key_byte;

   kbq_store #(
      .DEPTH (DEPTH),
      .DW    (8)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (push_data),
      .pop       (rd_strobe),
      .head_data (rd_data),
      .count     (count),
      .push_ok   (push_ok),
      .pop_ok    (pop_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= push_ok || (pop_ok && count != CW'(1));
   end

   assign rx_avail = (count != '0);
   assign rx_pulse = pulse_q;

   // R5
   pulse_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_ok |=> rx_pulse);

   // R5
   no_pulse_last_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_ok && !push && count == CW'(1)) |=> (!rx_pulse && !rx_avail));

   // R9
   reply_beats_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_valid && key_valid && !rd_strobe && count < CW'(DEPTH - 1))
      |=> (count == $past(count) + 1'b1));

endmodule

// File: tb/sim_kbd_reply_queue.sv
module sim_kbd_reply_queue;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       key_valid = 1'b0;
   logic [7:0] key_code = '0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_byte = '0;
   logic       rd_strobe = 1'b0;
   logic [7:0] rd_data;
   logic       rx_avail;
   logic       rx_pulse;

   int   n_checks = 0;
   int   n_errors = 0;
   bit   done = 1'b0;
   logic [7:0] exp_q[$];

   always #5 clk = ~clk;

   kbd_reply_queue u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .key_valid (key_valid),
      .key_code  (key_code),
      .cmd_valid (cmd_valid),
      .cmd_byte  (cmd_byte),
      .rd_strobe (rd_strobe),
      .rd_data   (rd_data),
      .rx_avail  (rx_avail),
      .rx_pulse  (rx_pulse)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] xl(input logic [7:0] c);
      return {c[7], c[6:0] ^ 7'h55};
   endfunction

   // driver: one key event per cycle, expected byte to scoreboard if kept
   task automatic send_key(input logic [7:0] c, input bit kept);
      @(negedge clk);
      key_valid = 1'b1;
      key_code  = c;
      @(posedge clk);
      #1;
      key_valid = 1'b0;
      if (kept) exp_q.push_back(xl(c));
   endtask

   task automatic send_cmd(input logic [7:0] b);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_byte  = b;
      @(posedge clk);
      #1;
      cmd_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #1;
   endtask

   // monitor: compares the head byte with the scoreboard, then pops it
   task automatic pop_chk(input string req);
      logic [7:0] e;
      @(negedge clk);
      e = (exp_q.size() != 0) ? exp_q.pop_front() : 8'h00;
      chk(rd_data == e, req, rd_data, e);
      rd_strobe = 1'b1;
      @(posedge clk);
      #1;
      rd_strobe = 1'b0;
      chk(rx_pulse == (exp_q.size() != 0), "R5 pulse after pop", rx_pulse, exp_q.size() != 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      idle(3);
      #1;
      // R1 reset state
      chk(rx_avail == 1'b0, "R1 rx_avail", rx_avail, 0);
      chk(rx_pulse == 1'b0, "R1 rx_pulse", rx_pulse, 0);
      chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(1);

      // R6 translation, R11 avail, R5 pulse after push
      send_key(8'h13, 1'b1);
      chk(rx_pulse == 1'b1, "R5 pulse after push", rx_pulse, 1);
      chk(rx_avail == 1'b1, "R11 avail after first push", rx_avail, 1);
      chk(rd_data == xl(8'h13), "R6 press translation", rd_data, xl(8'h13));
      send_key(8'h93, 1'b1);
      send_key(8'h00, 1'b1);
      send_key(8'hFF, 1'b1);
      idle(1);
      chk(rx_pulse == 1'b0, "R5 pulse is one cycle", rx_pulse, 0);
      // R2 order, R6 release bit
      pop_chk("R2 order");
      pop_chk("R6 release translation");
      pop_chk("R2 order");
      pop_chk("R6 release translation");
      chk(rx_avail == 1'b0, "R11 avail after last pop", rx_avail, 0);

      // R4 empty read
      @(negedge clk);
      chk(rd_data == 8'h00, "R4 empty read value", rd_data, 0);
      rd_strobe = 1'b1;
      @(posedge clk);
      #1;
      rd_strobe = 1'b0;
      chk(rx_avail == 1'b0, "R4 empty pop keeps empty", rx_avail, 0);
      chk(rx_pulse == 1'b0, "R4 empty pop no pulse", rx_pulse, 0);
      send_key(8'h21, 1'b1);
      pop_chk("R4 count not underflowed");
      chk(rx_avail == 1'b0, "R4 count not underflowed avail", rx_avail, 0);

      // R7 commands
      send_cmd(8'h01);
      exp_q.push_back(8'hFF);
      exp_q.push_back(8'h05);
      idle(1);
      chk(rx_avail == 1'b1, "R7 first reply byte timing", rx_avail, 1);
      chk(rd_data == 8'hFF, "R7 first reply byte", rd_data, 8'hFF);
      idle(2);
      pop_chk("R7 reset reply");
      pop_chk("R7 reset reply");
      send_cmd(8'h07);
      exp_q.push_back(8'hFE);
      exp_q.push_back(8'h20);
      idle(3);
      pop_chk("R7 layout reply");
      pop_chk("R7 layout reply");

      // R8 unknown commands
      send_cmd(8'h03);
      send_cmd(8'h81);
      idle(3);
      chk(rx_avail == 1'b0, "R8 unknown command ignored", rx_avail, 0);
      chk(rd_data == 8'h00, "R8 unknown command no data", rd_data, 0);

      // R9 reply priority and busy command
      send_cmd(8'h01);
      exp_q.push_back(8'hFF);
      send_key(8'h44, 1'b0);
      exp_q.push_back(8'h05);
      send_cmd(8'h07);
      idle(4);
      pop_chk("R9 reply over key");
      pop_chk("R9 reply over key");
      chk(rx_avail == 1'b0, "R9 key and busy command dropped", rx_avail, 0);

      // R10 simultaneous push and pop
      send_key(8'h05, 1'b1);
      send_key(8'h06, 1'b1);
      @(negedge clk);
      chk(rd_data == exp_q[0], "R10 head before", rd_data, exp_q[0]);
      void'(exp_q.pop_front());
      rd_strobe = 1'b1;
      key_valid = 1'b1;
      key_code  = 8'h07;
      @(posedge clk);
      #1;
      rd_strobe = 1'b0;
      key_valid = 1'b0;
      exp_q.push_back(xl(8'h07));
      chk(rx_avail == 1'b1, "R10 count kept", rx_avail, 1);
      pop_chk("R10 order after push and pop");
      pop_chk("R10 order after push and pop");
      chk(rx_avail == 1'b0, "R10 exactly two left", rx_avail, 0);

      // R3 fill to capacity then overflow
      for (int i = 0; i < 256; i++) send_key(8'(i), 1'b1);
      send_key(8'h2A, 1'b0);
      chk(rx_pulse == 1'b0, "R3 dropped push no pulse", rx_pulse, 0);
      chk(rd_data == xl(8'h00), "R3 head intact", rd_data, xl(8'h00));
      for (int i = 0; i < 256; i++) pop_chk("R3 full contents");
      chk(rx_avail == 1'b0, "R3 extra byte discarded", rx_avail, 0);
      chk(rd_data == 8'h00, "R3 empty after drain", rd_data, 0);

      finish_run();
   end

endmodule